// File: doc/BRIEF.md
# Receive Packet Streaming Source

This block drains a receive packet buffer into a user application over a streaming interface that carries data, start-of-packet, end-of-packet, valid and error. The buffer writes beats into the block one per cycle, tagging each packet as posted, non-posted or completion. Non-posted requests go to their own queue and all other traffic goes to a second queue. The application can hold back non-posted requests with a mask input while the rest of the traffic keeps moving.

The output uses a fixed ready latency of two cycles. A beat may appear on the output only if the sink held ready high two cycles earlier, so the sink never has to refuse a valid beat. Each beat carries one uncorrectable-error flag per byte lane. A flagged beat is issued with the error output high and with end-of-packet forced. Whatever remains of that packet is then discarded inside the block.

Top module: `rx_pkt_source`

## Requirements
- R1: Reset state. After reset, out_valid and out_err are low and in_ready is high.
- R2: Queue routing. in_kind 2'b01 marks a non-posted request and goes to the non-posted queue. 2'b00 (posted) and 2'b10 (completion) go to the other queue. Each queue issues its packets in write order. Every beat keeps its data, and a packet's beats keep their start and end markers.
- R3: Ready latency and no loss. out_valid in cycle c requires out_ready high in cycle c-2. When ready rises with data waiting, the first beat appears exactly two cycles later. No written beat is lost under backpressure.
- R4: Gaps. If the next beat of a started packet is not yet buffered, out_valid drops. The packet resumes without loss once the beat arrives, even while out_ready stays high.
- R5: Error signalling. out_err is high only together with out_valid. It is high on a beat for which any bit of in_byte_uncorr (one bit per data byte, bit i for byte i) was set, and only on such a beat.
- R6: Early termination. A flagged beat that is not the last of its packet is issued with out_eop high. out_valid is low in the next cycle. The rest of that packet never appears, and the following packet is delivered intact.
- R7: Mask. A non-posted packet may start on the output in cycle c only if np_mask was low in cycle c-1. Posted and completion packets keep flowing while np_mask is high.
- R8: A non-posted packet whose first beat has already been issued finishes normally when np_mask rises.
- R9: Bound after mask. While np_mask stays high, no more than NP_LIMIT non-posted packets start on the output. NP_LIMIT is 14 for a data width below 128 bits and 26 otherwise.
- R10: On mask release, held non-posted packets are issued in their original order.
- R11: Arbitration switches queues only at packet boundaries, so beats of different packets never interleave. When both queues hold a packet at a boundary, the queues alternate.
- R12: in_ready is low exactly when the queue selected by in_kind is full (QDEPTH beats). The other queue still accepts beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Buffer offers a beat |
| in_ready | output | 1 | Target queue has room for the offered beat |
| in_data | input | DW (64) | Beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_kind | input | 2 | Packet class: 00 posted, 01 non-posted, 10 completion |
| in_byte_uncorr | input | DW/8 (8) | Per-byte uncorrectable error flags |
| np_mask | input | 1 | Hold back new non-posted packets |
| out_ready | input | 1 | Sink ready, two-cycle latency |
| out_valid | output | 1 | Output beat valid |
| out_data | output | DW (64) | Output beat data |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet (forced on an error beat) |
| out_err | output | 1 | Uncorrectable error on this beat |

## Verification
A stale ready pipeline shows up as a valid beat in the second cycle after ready falls, or as a first beat that arrives one cycle too early or too late after ready rises. A wrong arbitration or packet-state register shows at the next packet boundary. Beats carry a packet identifier and a beat index, so an interleave, a missing marker or a reordered queue is visible on that very beat. A drain state that ends too early or too late shows within a few cycles of a cut packet: either stray beats without a start marker appear, or the next packet loses its head.

// File: rtl/rx_src_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the receive packet streaming source.
// Assumes packet class codes are fixed by the buffer that writes beats.
package rx_src_pkg;

    typedef enum logic [1:0] {
        KIND_POSTED     = 2'b00,
        KIND_NONPOSTED  = 2'b01,
        KIND_COMPLETION = 2'b10
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'b00,
        ARB_BUSY  = 2'b01,
        ARB_DRAIN = 2'b10
    } arb_state_e;

    // Number of non-posted packets that may still start after masking.
    function automatic int np_limit(input int dw);
        return (dw >= 128) ? 26 : 14;
    endfunction

endpackage

// File: rtl/rx_beat_fifo.sv
`timescale 1ns/1ps
// Module: rx_beat_fifo
// Show-ahead FIFO of packed beats. head is valid whenever empty is low.
// Assumes push is only issued when full is low and pop only when empty is low.
module rx_beat_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/rx_queue_arb.sv
`timescale 1ns/1ps
// Module: rx_queue_arb
// Chooses which queue feeds the output, switching only at packet boundaries,
// and discards the remainder of a packet cut short by an error beat.
// Assumes each queue holds well-formed packets (first head beat is a start).
module rx_queue_arb
    import rx_src_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic np_mask,
    input  logic ready_d1,
    input  logic np_empty,
    input  logic ot_empty,
    input  logic np_eop,
    input  logic np_err,
    input  logic ot_eop,
    input  logic ot_err,
    output logic emit,
    output logic pick_np,
    output logic pop_np,
    output logic pop_ot,
    output logic draining
);
    arb_state_e state;
    logic       sel_np;
    logic       prefer_np;
    logic       drop;
    logic       np_ok, ot_ok, sel_empty, p_eop, p_err;

    assign np_ok     = !np_empty && !np_mask;
    assign ot_ok     = !ot_empty;
    assign sel_empty = sel_np ? np_empty : ot_empty;
    assign p_eop     = pick_np ? np_eop : ot_eop;
    assign p_err     = pick_np ? np_err : ot_err;
    assign draining  = (state == ARB_DRAIN);

    // Decide which queue is read this cycle and whether the beat is issued.
    always_comb begin
        pick_np = sel_np;
        emit    = 1'b0;
        drop    = 1'b0;
        case (state)
            ARB_DRAIN: drop = !sel_empty;
            ARB_BUSY:  emit = ready_d1 && !sel_empty;
            default: begin
                pick_np = (np_ok && ot_ok) ? prefer_np : np_ok;
                emit    = ready_d1 && (np_ok || ot_ok);
            end
        endcase
    end

    assign pop_np = (emit || drop) && pick_np;
    assign pop_ot = (emit || drop) && !pick_np;

    // Packet-level state: current queue, fairness pointer, drain tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ARB_IDLE;
            sel_np    <= 1'b0;
            prefer_np <= 1'b0;
        end else begin
            if (emit && state == ARB_IDLE) begin
                sel_np    <= pick_np;
                prefer_np <= !pick_np;
            end
            if (emit) begin
                if (p_eop)      state <= ARB_IDLE;
                else if (p_err) state <= ARB_DRAIN;
                else            state <= ARB_BUSY;
            end else if (drop && p_eop) begin
                state <= ARB_IDLE;
            end
        end
    end

    p_single_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_np, pop_ot}));
    p_hold_queue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_BUSY) |=> $stable(sel_np));

endmodule

// File: rtl/rx_pkt_source.sv
`timescale 1ns/1ps
// Module: rx_pkt_source
// Receive streaming source: two beat queues (non-posted, other), a
// boundary arbiter and a registered output stage obeying a two-cycle
// ready latency. Beats flagged uncorrectable end their packet early.
// Assumes the writer presents well-formed packets of a single class.
module rx_pkt_source
    import rx_src_pkg::*;
#(
    parameter int DW     = 64,
    parameter int QDEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [1:0]    in_kind,
    input  logic [DW/8-1:0] in_byte_uncorr,
    input  logic          np_mask,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sop,
    output logic          out_eop,
    output logic          out_err
);
    localparam int BW       = DW + 3;
    localparam int NQ       = 2;
    localparam int Q_OT     = 0;
    localparam int Q_NP     = 1;
    localparam int NP_LIMIT = np_limit(DW);
    localparam int LCW      = $clog2(NP_LIMIT + 2);

    logic [BW-1:0] q_head [NQ];
    logic [NQ-1:0] q_push, q_pop, q_empty, q_full;
    logic [BW-1:0] wr_beat, sel_beat;
    logic          to_np, ready_d1, emit, pick_np, draining, out_from_np;

    assign to_np    = (in_kind == 2'(KIND_NONPOSTED));
    assign in_ready = to_np ? !q_full[Q_NP] : !q_full[Q_OT];
    assign wr_beat  = {|in_byte_uncorr, in_eop, in_sop, in_data};
    assign q_push[Q_NP] = in_valid && in_ready && to_np;
    assign q_push[Q_OT] = in_valid && in_ready && !to_np;

    // One show-ahead queue per traffic class.
    for (genvar gq = 0; gq < NQ; gq++) begin : g_queue
        rx_beat_fifo #(.W(BW), .DEPTH(QDEPTH)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[gq]),
            .wdata (wr_beat),
            .pop   (q_pop[gq]),
            .head  (q_head[gq]),
            .empty (q_empty[gq]),
            .full  (q_full[gq])
        );
    end

    rx_queue_arb i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .np_mask  (np_mask),
        .ready_d1 (ready_d1),
        .np_empty (q_empty[Q_NP]),
        .ot_empty (q_empty[Q_OT]),
        .np_eop   (q_head[Q_NP][DW+1]),
        .np_err   (q_head[Q_NP][DW+2]),
        .ot_eop   (q_head[Q_OT][DW+1]),
        .ot_err   (q_head[Q_OT][DW+2]),
        .emit     (emit),
        .pick_np  (pick_np),
        .pop_np   (q_pop[Q_NP]),
        .pop_ot   (q_pop[Q_OT]),
        .draining (draining)
    );

    assign sel_beat = pick_np ? q_head[Q_NP] : q_head[Q_OT];

    // Ready history: one register here plus the output register gives latency 2.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_d1 <= 1'b0;
        else        ready_d1 <= out_ready;
    end

    // Output register: load the issued beat, force end on an error beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sop     <= 1'b0;
            out_eop     <= 1'b0;
            out_err     <= 1'b0;
            out_from_np <= 1'b0;
            out_data    <= '0;
        end else begin
            out_valid <= emit;
            out_sop   <= emit && sel_beat[DW];
            out_eop   <= emit && (sel_beat[DW+1] || sel_beat[DW+2]);
            out_err   <= emit && sel_beat[DW+2];
            if (emit) begin
                out_data    <= sel_beat[DW-1:0];
                out_from_np <= pick_np;
            end
        end
    end

    // Checker-only count of non-posted starts while the mask is held.
    logic [LCW-1:0] np_starts_masked;
    always_ff @(posedge clk) begin
        if (!rst_n || !np_mask) np_starts_masked <= '0;
        else if (out_valid && out_sop && out_from_np &&
                 np_starts_masked != LCW'(NP_LIMIT + 1))
            np_starts_masked <= np_starts_masked + 1'b1;
    end

    p_ready_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_ready, 2));
    p_err_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
    p_err_ends_pkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eop);
    p_quiet_after_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        draining |=> !out_valid);
    p_np_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && out_from_np) |-> !$past(np_mask));
    p_np_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        np_starts_masked <= LCW'(NP_LIMIT));

endmodule

// File: tb/test_rx_pkt_source.sv
`timescale 1ns/1ps
module test_rx_pkt_source;
    import rx_src_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 64;
    localparam int NB         = DW / 8;
    localparam int QDEPTH     = 16;
    localparam int NP_LIMIT   = 14;
    localparam int CAP        = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_sop = 1'b0, in_eop = 1'b0;
    logic [1:0]    in_kind = 2'b00;
    logic [NB-1:0] in_byte_uncorr = '0;
    logic          np_mask = 1'b0;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_sop, out_eop, out_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pkt_source #(.DW(DW), .QDEPTH(QDEPTH)) i_rx_pkt_source (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_kind(in_kind),
        .in_byte_uncorr(in_byte_uncorr), .np_mask(np_mask), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_err(out_err)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int lat_viol = 0, err_viol = 0, np_masked_starts = 0;
    logic rdy_h1 = 1'b0, rdy_h2 = 1'b0;
    logic [DW-1:0] cap_d [CAP];
    logic cap_sop [CAP], cap_eop [CAP], cap_err [CAP];
    int cap_cyc [CAP];
    int cap_n = 0;
    bit is_np_id [256];

    // Output monitor: capture beats and track port-level rules.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (out_valid && !rdy_h2) lat_viol = lat_viol + 1;
            if (out_err && !out_valid) err_viol = err_viol + 1;
            if (out_valid && out_sop && np_mask && is_np_id[out_data[55:48]])
                np_masked_starts = np_masked_starts + 1;
            if (out_valid && cap_n < CAP) begin
                cap_d[cap_n] = out_data;  cap_sop[cap_n] = out_sop;
                cap_eop[cap_n] = out_eop; cap_err[cap_n] = out_err;
                cap_cyc[cap_n] = cyc;     cap_n = cap_n + 1;
            end
        end
        rdy_h2 = rdy_h1;
        rdy_h1 = out_ready;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int bid(input int k);
        return int'(cap_d[k][63:48]);
    endfunction

    task automatic send_beat(input logic [1:0] kind, input int id, input int idx,
                             input bit sop, input bit eop, input int errbyte);
        in_valid = 1'b1; in_kind = kind; in_sop = sop; in_eop = eop;
        in_data = {16'(id), 16'(idx), 32'hC0DE_0000};
        in_byte_uncorr = (errbyte >= 0) ? NB'(1) << errbyte : '0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_byte_uncorr = '0;
    endtask

    task automatic send_pkt(input logic [1:0] kind, input int id, input int n,
                            input int errat, input int errbyte);
        is_np_id[id] = (kind == 2'(KIND_NONPOSTED));
        for (int i = 0; i < n; i++)
            send_beat(kind, id, i, i == 0, i == n - 1, (i == errat) ? errbyte : -1);
    endtask

    // Compare n captured beats from index k against packet id; cut marks the error beat.
    task automatic expect_pkt(input int k, input int id, input int n, input int cut,
                              input string req);
        bit ok = 1'b1;
        int bad_at = -1;
        for (int i = 0; i < n; i++) begin
            if (k + i >= cap_n ||
                bid(k + i) != id || int'(cap_d[k+i][47:32]) != i ||
                cap_sop[k+i] != (i == 0) || cap_eop[k+i] != (i == n - 1) ||
                cap_err[k+i] != (i == cut)) begin
                if (ok) bad_at = i;
                ok = 1'b0;
            end
        end
        check(ok, req, $sformatf("packet %0d beat mismatch at beat (id seen)", id),
              (ok || k + bad_at >= cap_n) ? id : bid(k + bad_at), id);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(out_err == 1'b0, "R1", "out_err after reset", out_err, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        wait_cyc(1);
    endtask

    task automatic t_basic();
        int b;
        out_ready = 1'b1; wait_cyc(3);
        b = cap_n;
        send_pkt(2'(KIND_POSTED), 1, 3, -1, 0);
        send_pkt(2'(KIND_COMPLETION), 2, 1, -1, 0);
        send_pkt(2'(KIND_POSTED), 3, 2, -1, 0);
        wait_cyc(10);
        check(cap_n - b == 6, "R2", "beat count", cap_n - b, 6);
        expect_pkt(b, 1, 3, -1, "R2");
        expect_pkt(b + 3, 2, 1, -1, "R2");
        expect_pkt(b + 4, 3, 2, -1, "R2");
    endtask

    task automatic t_backpressure();
        int b;
        b = cap_n;
        fork
            begin
                send_pkt(2'(KIND_POSTED), 4, 3, -1, 0);
                send_pkt(2'(KIND_COMPLETION), 5, 3, -1, 0);
                send_pkt(2'(KIND_POSTED), 6, 2, -1, 0);
            end
            begin
                for (int i = 0; i < 40; i++) begin
                    @(posedge clk); #1;
                    out_ready = !((i % 4 == 1) || (i % 7 == 3) || (i % 9 == 0));
                end
            end
        join
        out_ready = 1'b1;
        wait_cyc(12);
        check(cap_n - b == 8, "R3", "beats delivered under backpressure", cap_n - b, 8);
        expect_pkt(b, 4, 3, -1, "R3");
        expect_pkt(b + 3, 5, 3, -1, "R3");
        expect_pkt(b + 6, 6, 2, -1, "R3");
        check(lat_viol == 0, "R3", "valid without ready two cycles before", lat_viol, 0);
    endtask

    task automatic t_gap();
        int b;
        out_ready = 1'b1; wait_cyc(2);
        b = cap_n;
        send_beat(2'(KIND_POSTED), 7, 0, 1'b1, 1'b0, -1);
        wait_cyc(5);
        send_beat(2'(KIND_POSTED), 7, 1, 1'b0, 1'b1, -1);
        wait_cyc(5);
        check(cap_n - b == 2, "R4", "beats across gap", cap_n - b, 2);
        expect_pkt(b, 7, 2, -1, "R4");
        check(cap_cyc[b+1] - cap_cyc[b] >= 5, "R4", "valid dropped inside packet",
              cap_cyc[b+1] - cap_cyc[b], 5);
    endtask

    task automatic t_error();
        int b;
        out_ready = 1'b1; wait_cyc(2);
        b = cap_n;
        send_pkt(2'(KIND_POSTED), 20, 4, 1, 3);
        send_pkt(2'(KIND_POSTED), 21, 2, -1, 0);
        send_pkt(2'(KIND_COMPLETION), 22, 2, 1, 7);
        wait_cyc(15);
        check(cap_n - b == 6, "R6", "beats after cut", cap_n - b, 6);
        expect_pkt(b, 20, 2, 1, "R6");
        check(cap_cyc[b+2] > cap_cyc[b+1] + 1, "R6", "valid low after early eop",
              cap_cyc[b+2] - cap_cyc[b+1], 2);
        expect_pkt(b + 2, 21, 2, -1, "R6");
        expect_pkt(b + 4, 22, 2, 1, "R5");
        check(err_viol == 0, "R5", "error without valid", err_viol, 0);
    endtask

    task automatic t_mask();
        int b;
        out_ready = 1'b1; np_mask = 1'b1; wait_cyc(2);
        b = cap_n;
        send_pkt(2'(KIND_NONPOSTED), 10, 2, -1, 0);
        send_pkt(2'(KIND_NONPOSTED), 11, 2, -1, 0);
        send_pkt(2'(KIND_POSTED), 12, 2, -1, 0);
        wait_cyc(15);
        check(cap_n - b == 2, "R7", "only posted passes under mask", cap_n - b, 2);
        expect_pkt(b, 12, 2, -1, "R7");
        check(np_masked_starts == 0, "R7", "non-posted start under mask", np_masked_starts, 0);
        check(np_masked_starts <= NP_LIMIT, "R9", "starts after mask", np_masked_starts, NP_LIMIT);
        np_mask = 1'b0;
        wait_cyc(15);
        check(cap_n - b == 6, "R10", "held packets released", cap_n - b, 6);
        expect_pkt(b + 2, 10, 2, -1, "R10");
        expect_pkt(b + 4, 11, 2, -1, "R10");
    endtask

    task automatic t_mask_mid();
        int b;
        out_ready = 1'b1; np_mask = 1'b0; wait_cyc(2);
        b = cap_n;
        is_np_id[13] = 1'b1;
        send_beat(2'(KIND_NONPOSTED), 13, 0, 1'b1, 1'b0, -1);
        wait_cyc(4);
        np_mask = 1'b1;
        send_beat(2'(KIND_NONPOSTED), 13, 1, 1'b0, 1'b0, -1);
        send_beat(2'(KIND_NONPOSTED), 13, 2, 1'b0, 1'b1, -1);
        send_pkt(2'(KIND_POSTED), 14, 1, -1, 0);
        wait_cyc(10);
        check(cap_n - b == 4, "R8", "started request completes", cap_n - b, 4);
        expect_pkt(b, 13, 3, -1, "R8");
        expect_pkt(b + 3, 14, 1, -1, "R8");
        np_mask = 1'b0;
        wait_cyc(5);
    endtask

    task automatic t_rr();
        int b, rise, p, k, id, n;
        int ids [4];
        bit ok;
        out_ready = 1'b0; wait_cyc(3);
        b = cap_n;
        send_pkt(2'(KIND_NONPOSTED), 30, 2, -1, 0);
        send_pkt(2'(KIND_POSTED), 31, 2, -1, 0);
        send_pkt(2'(KIND_NONPOSTED), 32, 1, -1, 0);
        send_pkt(2'(KIND_COMPLETION), 33, 2, -1, 0);
        wait_cyc(5);
        check(cap_n - b == 0, "R3", "no beat while ready low", cap_n - b, 0);
        out_ready = 1'b1;
        rise = cyc + 1;
        wait_cyc(20);
        check(cap_n - b == 7, "R11", "beats after release", cap_n - b, 7);
        check(cap_cyc[b] == rise + 2, "R3", "first beat two cycles after ready",
              cap_cyc[b] - rise, 2);
        p = 0; k = b;
        while (k < cap_n && p < 4) begin
            id = bid(k);
            n = (id == 32) ? 1 : 2;
            expect_pkt(k, id, n, -1, "R11");
            ids[p] = id; p++; k += n;
        end
        ok = (p == 4) && ((ids[0] == 30 && ids[1] == 31 && ids[2] == 32 && ids[3] == 33) ||
                          (ids[0] == 31 && ids[1] == 30 && ids[2] == 33 && ids[3] == 32));
        check(ok, "R11", "alternating packet order (first id)", ids[0], 30);
    endtask

    task automatic t_full();
        int b;
        out_ready = 1'b0; wait_cyc(3);
        b = cap_n;
        for (int i = 0; i < QDEPTH; i++)
            send_beat(2'(KIND_POSTED), 40, i, i == 0, i == QDEPTH - 1, -1);
        in_kind = 2'(KIND_POSTED);
        @(negedge clk);
        check(in_ready == 1'b0, "R12", "in_ready with full target queue", in_ready, 0);
        in_kind = 2'(KIND_NONPOSTED);
        #1;
        check(in_ready == 1'b1, "R12", "in_ready for the other queue", in_ready, 1);
        @(posedge clk); #1;
        out_ready = 1'b1;
        wait_cyc(30);
        check(cap_n - b == QDEPTH, "R12", "full queue drains", cap_n - b, QDEPTH);
        expect_pkt(b, 40, QDEPTH, -1, "R12");
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_basic();
        t_backpressure();
        t_gap();
        t_error();
        t_mask();
        t_mask_mid();
        t_rr();
        t_full();
        check(lat_viol == 0, "R3", "ready latency over whole run", lat_viol, 0);
        check(err_viol == 0, "R5", "error only with valid over whole run", err_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 50000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule